// File: doc/BRIEF.md
# Banked Scratchpad Conflict Serializer

This block sits in front of a scratchpad built from sixteen independent banks, each one 32-bit word wide and able to serve one word per clock. Each cycle it can take one request from a group of sixteen lanes. A request carries one direction (read or write) for the whole group, an active bit per lane and one word address per lane. The low four address bits pick the bank and the remaining bits pick the row inside that bank. Words at consecutive addresses therefore sit in consecutive banks.

Lanes that target different banks are served together. Lanes that target different rows of the same bank conflict, and the block splits them into sequential passes. In each pass every bank serves exactly one row. All lanes that want that row are served at once, so lanes that share a word never cost an extra pass. The number of passes equals the largest number of distinct rows requested from any single bank. When every active lane names the same word, the whole request completes in one pass.

While passes are in progress, `busy` is high and new requests are refused. After the last pass, `done` pulses for one cycle and the read data for all sixteen lanes is presented together. When several lanes write the same word, the value from the highest-numbered active lane is the one stored.

Top module: `bank_conflict_serializer`

## Requirements
- R1: A lane's bank is its word address modulo 16 (address bits [3:0]) and its row is the address divided by 16 (bits [7:4]). A request whose active lanes all hit different banks completes in one pass.
- R2: After reset, `busy` and `done` are 0 and `rd_data` is all zero.
- R3: A request is accepted on a clock edge where `req_valid` is 1 and `busy` is 0. A request presented while `busy` is 1 is ignored, and its writes never reach the scratchpad.
- R4: An accepted request with at least one active lane raises `busy` for exactly P cycles, where P is the largest count of distinct rows requested in any one bank. In the first cycle after that, `busy` is 0 and `done` is 1 for one cycle.
- R5: When all active lanes read the same word, the request takes one pass and every active lane returns that word.
- R6: Lanes that name the same word of a bank are served in the same pass. Only distinct rows within a bank add passes.
- R7: For addresses base + s*lane over all sixteen lanes, an odd stride s takes one pass, s=2 takes 2 passes, s=8 takes 8 passes and s=16 takes 16 passes.
- R8: When several active lanes write the same word, the word keeps the data of the highest-numbered of those lanes.
- R9: Inactive lanes return zero in `rd_data` and write nothing. A request with no active lane sets `done` in the next cycle and never raises `busy`.
- R10: At the end of a write request, `rd_data` is all zero.
- R11: `rd_data` holds its value after `done` until the next request is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_active | input | 16 | Per-lane active bits, bit i for lane i |
| req_addr | input | 128 | Per-lane word address, lane i in bits [8i+7:8i] |
| req_wdata | input | 512 | Per-lane write data, lane i in bits [32i+31:32i] |
| busy | output | 1 | Passes in progress; requests refused |
| done | output | 1 | One-cycle pulse when the request has completed |
| rd_data | output | 512 | Per-lane read data, lane i in bits [32i+31:32i] |

## Verification
Several properties are checked on every cycle. `done` never coincides with `busy`, and each fall of `busy` comes with `done`. `busy` rises only after a presented request and stays high until completion. An empty request finishes at once, and no run of `busy` is longer than sixteen cycles. Only the bench scenarios can show the exact pass count for each address pattern, the per-lane read data, the broadcast cases, the write priority among lanes sharing a word, and that a request made while busy leaves the scratchpad untouched. The bench shows these by comparing against a behavioural model of the banks.

// File: rtl/bcs_pkg.sv
package bcs_pkg;
  typedef enum logic {
    OP_READ  = 1'b0,
    OP_WRITE = 1'b1
  } op_e;
endpackage

// File: rtl/bcs_pass_select.sv
// Chooses, for one pass, a single row per bank and the set of lanes it serves.
module bcs_pass_select #(
  parameter int LANES = 16,
  parameter int BANKS = 16,
  parameter int AW    = 8,
  localparam int BW   = $clog2(BANKS),
  localparam int RW   = AW - BW,
  localparam int LW   = $clog2(LANES)
) (
  input  logic [LANES-1:0]           pending,
  input  logic [LANES-1:0][AW-1:0]   lane_addr,
  output logic [LANES-1:0]           served,
  output logic [BANKS-1:0]           bank_en,
  output logic [BANKS-1:0][RW-1:0]   bank_row,
  output logic [BANKS-1:0][LW-1:0]   bank_wlane
);

  always_comb begin
    bank_en    = '0;
    bank_row   = '0;
    bank_wlane = '0;
    served     = '0;
    // lowest pending lane of each bank decides the row served this pass
    for (int b = 0; b < BANKS; b++) begin
      for (int l = 0; l < LANES; l++) begin
        if (pending[l] && (lane_addr[l][BW-1:0] == BW'(b)) && !bank_en[b]) begin
          bank_en[b]  = 1'b1;
          bank_row[b] = lane_addr[l][AW-1:BW];
        end
      end
    end
    // every pending lane asking for that row rides along
    for (int l = 0; l < LANES; l++) begin
      if (pending[l] && (lane_addr[l][AW-1:BW] == bank_row[lane_addr[l][BW-1:0]]))
        served[l] = 1'b1;
    end
    // highest served lane of each bank supplies the write data
    for (int b = 0; b < BANKS; b++) begin
      for (int l = 0; l < LANES; l++) begin
        if (served[l] && (lane_addr[l][BW-1:0] == BW'(b)))
          bank_wlane[b] = LW'(l);
      end
    end
  end

endmodule

// File: rtl/bcs_bank_array.sv
// Storage: one single-port word array per bank, combinational read.
module bcs_bank_array #(
  parameter int BANKS = 16,
  parameter int DEPTH = 16,
  parameter int DW    = 32,
  localparam int RW   = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic [BANKS-1:0]           wr_en,
  input  logic [BANKS-1:0][RW-1:0]   row,
  input  logic [BANKS-1:0][DW-1:0]   wdata,
  output logic [BANKS-1:0][DW-1:0]   rdata
);

  for (genvar g = 0; g < BANKS; g++) begin : g_bank
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
      if (wr_en[g]) store[row[g]] <= wdata[g];
    end

    assign rdata[g] = store[row[g]];
  end

endmodule

// File: rtl/bank_conflict_serializer.sv
module bank_conflict_serializer
  import bcs_pkg::*;
#(
  parameter int LANES          = 16,
  parameter int BANKS          = 16,
  parameter int WORDS_PER_BANK = 16,
  parameter int DW             = 32,
  localparam int BW            = $clog2(BANKS),
  localparam int RW            = $clog2(WORDS_PER_BANK),
  localparam int AW            = BW + RW,
  localparam int LW            = $clog2(LANES)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [LANES-1:0]    req_active,
  input  logic [LANES*AW-1:0] req_addr,
  input  logic [LANES*DW-1:0] req_wdata,
  output logic                busy,
  output logic                done,
  output logic [LANES*DW-1:0] rd_data
);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // request views
  logic [LANES-1:0][AW-1:0] in_addr;
  logic [LANES-1:0][DW-1:0] in_wdata;
  assign in_addr  = req_addr;
  assign in_wdata = req_wdata;

  // state
  logic                     busy_q, busy_d;
  logic                     done_q, done_d;
  op_e                      op_q;
  logic [LANES-1:0]         pend_q, pend_d;
  logic [LANES-1:0][AW-1:0] addr_q;
  logic [LANES-1:0][DW-1:0] wdata_q;
  logic [LANES-1:0][DW-1:0] rd_q, rd_d;

  logic accept;
  logic cap_en;
  logic rd_en;

  // pass selection and storage
  logic [LANES-1:0]         served;
  logic [BANKS-1:0]         bank_en;
  logic [BANKS-1:0][RW-1:0] bank_row;
  logic [BANKS-1:0][LW-1:0] bank_wlane;
  logic [BANKS-1:0]         bank_we;
  logic [BANKS-1:0][DW-1:0] bank_wdata;
  logic [BANKS-1:0][DW-1:0] bank_rdata;
  logic [LANES-1:0]         pend_left;

  bcs_pass_select #(
    .LANES (LANES),
    .BANKS (BANKS),
    .AW    (AW)
  ) i_select (
    .pending    (pend_q),
    .lane_addr  (addr_q),
    .served     (served),
    .bank_en    (bank_en),
    .bank_row   (bank_row),
    .bank_wlane (bank_wlane)
  );

  always_comb begin
    for (int b = 0; b < BANKS; b++) begin
      bank_we[b]    = busy_q && (op_q == OP_WRITE) && bank_en[b];
      bank_wdata[b] = wdata_q[bank_wlane[b]];
    end
  end

  bcs_bank_array #(
    .BANKS (BANKS),
    .DEPTH (WORDS_PER_BANK),
    .DW    (DW)
  ) i_banks (
    .clk   (clk),
    .wr_en (bank_we),
    .row   (bank_row),
    .wdata (bank_wdata),
    .rdata (bank_rdata)
  );

  assign accept    = req_valid && !busy_q;
  assign pend_left = pend_q & ~served;
  assign cap_en    = accept;
  assign rd_en     = accept || busy_q;

  // next state
  always_comb begin
    busy_d = busy_q;
    done_d = 1'b0;
    pend_d = pend_q;
    rd_d   = rd_q;
    if (accept) begin
      pend_d = req_active;
      rd_d   = '0;
      if (req_active == '0) done_d = 1'b1;
      else                  busy_d = 1'b1;
    end else if (busy_q) begin
      pend_d = pend_left;
      for (int l = 0; l < LANES; l++) begin
        if (served[l] && (op_q == OP_READ))
          rd_d[l] = bank_rdata[addr_q[l][BW-1:0]];
      end
      if (pend_left == '0) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      pend_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
      pend_q <= pend_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      op_q    <= OP_READ;
      addr_q  <= '0;
      wdata_q <= '0;
    end else if (cap_en) begin
      op_q    <= op_e'(req_write);
      addr_q  <= in_addr;
      wdata_q <= in_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)  rd_q <= '0;
    else if (rd_en)   rd_q <= rd_d;
  end

  assign busy    = busy_q;
  assign done    = done_q;
  assign rd_data = rd_q;

endmodule

// File: rtl/bcs_checker.sv
module bcs_checker #(
  parameter int LANES = 16
) (
  input logic             clk,
  input logic             rst_sync_n,
  input logic             req_valid,
  input logic [LANES-1:0] req_active,
  input logic             busy,
  input logic             done
);

  localparam int CW = $clog2(LANES + 2);
  logic [CW-1:0] busy_run;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)                          busy_run <= '0;
    else if (busy && (busy_run != {CW{1'b1}})) busy_run <= busy_run + 1'b1;
    else if (!busy)                           busy_run <= '0;
  end

  p_done_idle_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> !busy);

  p_fall_done_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(busy) |-> done);

  p_busy_hold_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy |=> (busy || done));

  p_start_accept_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(busy) |-> $past(req_valid));

  p_empty_done_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (req_valid && !busy && (req_active == '0)) |=> (done && !busy));

  p_pass_bound_r7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    busy_run <= CW'(LANES));

endmodule

bind bank_conflict_serializer bcs_checker #(.LANES(LANES)) i_bcs_checker (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .req_valid  (req_valid),
  .req_active (req_active),
  .busy       (busy),
  .done       (done)
);

// File: tb/test_bank_conflict_serializer.sv
`timescale 1ns/1ps
module test_bank_conflict_serializer;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic         req_write;
  logic [15:0]  req_active;
  logic [127:0] req_addr;
  logic [511:0] req_wdata;
  logic         busy;
  logic         done;
  logic [511:0] rd_data;

  int checks   = 0;
  int failures = 0;
  int cycles   = 0;

  logic [31:0] mem_m [256];

  always #10 clk = ~clk;

  bank_conflict_serializer i_bank_conflict_serializer (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_active (req_active),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .busy       (busy),
    .done       (done),
    .rd_data    (rd_data)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      failures++;
      $display("FAIL watchdog expired: actual=%0d cycles expected<150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string msg, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", msg, act, exp);
    end
  endtask

  // behavioural pass count: the deepest list of distinct rows in any bank
  function automatic int model_passes(input logic [15:0] act, input int unsigned a[16]);
    int p = 0;
    for (int b = 0; b < 16; b++) begin
      int unsigned rows[$];
      for (int l = 0; l < 16; l++) begin
        if (act[l] && (a[l] % 16) == b) begin
          bit seen = 0;
          foreach (rows[i]) if (rows[i] == a[l] / 16) seen = 1;
          if (!seen) rows.push_back(a[l] / 16);
        end
      end
      if (rows.size() > p) p = rows.size();
    end
    return p;
  endfunction

  task automatic do_req(input bit wr, input logic [15:0] act, input int unsigned a[16],
                        input logic [31:0] d[16], input bit intrude, input string rq);
    int k;
    logic [31:0] exp [16];
    k = model_passes(act, a);
    for (int l = 0; l < 16; l++) exp[l] = (!wr && act[l]) ? mem_m[a[l]] : 32'h0;
    @(negedge clk);
    req_write  = wr;
    req_active = act;
    for (int l = 0; l < 16; l++) begin
      req_addr[l*8 +: 8]   = a[l][7:0];
      req_wdata[l*32 +: 32] = d[l];
    end
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    for (int i = 0; i < k; i++) begin
      chk(busy === 1'b1 && done === 1'b0, {rq, " R4 busy during pass"}, {busy, done}, 2'b10);
      if (intrude && i == 0 && k > 1) begin
        req_write  = 1'b1;
        req_active = 16'hFFFF;
        for (int l = 0; l < 16; l++) begin
          req_addr[l*8 +: 8]    = 8'd100;
          req_wdata[l*32 +: 32] = 32'hDEAD_0000 | l;
        end
        req_valid = 1'b1;
      end else begin
        req_valid = 1'b0;
      end
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(busy === 1'b0 && done === 1'b1, {rq, " R4 done after last pass"}, {busy, done}, 2'b01);
    for (int l = 0; l < 16; l++)
      chk(rd_data[l*32 +: 32] === exp[l], {rq, " lane data"}, rd_data[l*32 +: 32], exp[l]);
    if (wr) for (int l = 0; l < 16; l++) if (act[l]) mem_m[a[l]] = d[l];
  endtask

  initial begin
    int unsigned a[16];
    logic [31:0] d[16];
    logic [511:0] held;

    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_active = '0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R2 reset flags", {busy, done}, 2'b00);
    chk(rd_data === '0, "R2 reset rd_data", rd_data[63:0], 64'h0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R2 idle after reset", {busy, done}, 2'b00);

    // fill every word, stride 1 per row: one pass each (R1)
    for (int r = 0; r < 16; r++) begin
      for (int l = 0; l < 16; l++) begin
        a[l] = r * 16 + l;
        d[l] = 32'h1000_0000 + a[l] * 32'h0001_0003;
      end
      do_req(1'b1, 16'hFFFF, a, d, 1'b0, "R1 R10 fill");
    end

    for (int l = 0; l < 16; l++) begin a[l] = 5 + l; d[l] = '0; end
    do_req(1'b0, 16'hFFFF, a, d, 1'b0, "R1 stride1 read");
    for (int l = 0; l < 16; l++) a[l] = (7 + 3 * l) % 256;
    do_req(1'b0, 16'hFFFF, a, d, 1'b0, "R7 stride3");
    for (int l = 0; l < 16; l++) a[l] = 2 * l;
    do_req(1'b0, 16'hFFFF, a, d, 1'b0, "R7 stride2");
    for (int l = 0; l < 16; l++) a[l] = 8 * l;
    do_req(1'b0, 16'hFFFF, a, d, 1'b0, "R7 stride8");
    for (int l = 0; l < 16; l++) a[l] = 16 * l;
    do_req(1'b0, 16'hFFFF, a, d, 1'b0, "R7 stride16");

    for (int l = 0; l < 16; l++) a[l] = 37;
    do_req(1'b0, 16'hFFFF, a, d, 1'b0, "R5 broadcast");
    do_req(1'b0, 16'h0810, a, d, 1'b0, "R5 broadcast sparse");

    for (int l = 0; l < 16; l++) a[l] = (l < 8) ? 3 : 19;
    do_req(1'b0, 16'hFFFF, a, d, 1'b0, "R6 two rows one bank");
    for (int l = 0; l < 16; l++) a[l] = (l < 8) ? 3 : 4;
    do_req(1'b0, 16'hFFFF, a, d, 1'b0, "R6 shared words");

    for (int l = 0; l < 16; l++) a[l] = 200 + l;
    do_req(1'b0, 16'h00A5, a, d, 1'b0, "R9 inactive lanes");
    do_req(1'b0, 16'h0000, a, d, 1'b0, "R9 empty mask");

    for (int l = 0; l < 16; l++) begin a[l] = 50; d[l] = 32'hC0DE_0000 | l; end
    do_req(1'b1, 16'hFFFF, a, d, 1'b0, "R8 R10 same word write");
    do_req(1'b0, 16'h0001, a, d, 1'b0, "R8 readback lane15 value");
    for (int l = 0; l < 16; l++) begin a[l] = 51; d[l] = 32'hBEEF_0000 | l; end
    do_req(1'b1, 16'h0F0F, a, d, 1'b0, "R8 masked same word write");
    do_req(1'b0, 16'h8000, a, d, 1'b0, "R8 readback lane11 value");

    // request while busy must be ignored
    for (int l = 0; l < 16; l++) a[l] = 8 * l;
    do_req(1'b0, 16'hFFFF, a, d, 1'b1, "R3 busy intrusion");
    for (int l = 0; l < 16; l++) a[l] = 100;
    do_req(1'b0, 16'hFFFF, a, d, 1'b0, "R3 intrusion left word");

    // data holds after done
    held = rd_data;
    repeat (3) begin
      @(negedge clk);
      chk(rd_data === held, "R11 rd_data held", rd_data[63:0], held[63:0]);
      chk(done === 1'b0 && busy === 1'b0, "R4 done single pulse", {busy, done}, 2'b00);
    end

    // mixed random traffic over a narrow range to force conflicts
    for (int t = 0; t < 40; t++) begin
      bit wr;
      logic [15:0] m;
      wr = ($urandom % 4) == 0;
      m  = 16'($urandom);
      for (int l = 0; l < 16; l++) begin
        a[l] = $urandom % 64;
        d[l] = $urandom;
      end
      do_req(wr, m, a, d, 1'b0, "R4 R6 R8 random");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule